// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block guards a system against a stalled processor. It holds a 64-bit counter and a 64-bit limit. Software arms it by writing two 16-bit keys, in order, to a control register. Once running, the counter advances every clock. A single-cycle reset request is raised when the counter reaches the limit. A reset request is also raised at once if software writes anything other than a recognised key.

Software services the watchdog by writing the arming key and then the go key again. This pair returns the count to zero. The watchdog responds only while the surrounding timer is set to its watchdog mode and both of its halves are out of reset. After it has started, nothing except the block reset stops it: there is no way to disarm it. After it has fired, it stays silent until that reset.

Top module: `keyed_wdog_top`

## Requirements
- R1: While rstN is low and after its release, rstReq is 0, the watchdog is idle and the limit is zero. An idle watchdog never requests reset, even with a zero limit.
- R2: Control writes have an effect only while timMode equals 2 and both bits of halfRel are 1. Otherwise they are ignored, and a running count holds its value.
- R3: A write to offset 0x28 with key field wrData[31:16] = 0xA5C6 and enable bit wrData[14] = 1 moves an idle watchdog to the armed state. The same key with the enable bit at 0 is ignored.
- R4: A write of key 0xDA7E to offset 0x28 while armed starts the watchdog, with its count at zero. The go key written while idle is ignored.
- R5: While armed, a write to offset 0x28 with any key other than 0xDA7E returns the watchdog to idle. No reset request is raised.
- R6: While running, the count rises by one per clock. The limit is 64 bits wide: the low word is written at offset 0x18 and the high word at offset 0x1C. The cycle in which the full 64-bit count equals the full 64-bit limit raises rstReq on the next clock. A limit of P therefore gives rstReq P+1 clocks after the start write, and a zero limit fires on the first clock after start.
- R7: While running, a write to offset 0x28 whose key is neither 0xA5C6 nor 0xDA7E raises rstReq on the clock that takes the write. An example is 0x00004000. The go key alone, without a preceding arming key, is harmless and does not restart the count.
- R8: While running, the arming key followed later by the go key restarts the count from zero on the go write. Extra arming keys written in between are allowed.
- R9: Once running, the enable bit is ignored. A key write with wrData[14] = 0 acts exactly as the same key with the bit set, so the watchdog cannot be disarmed.
- R10: rstReq is a single-cycle pulse. After it, the watchdog stays tripped and raises no further pulse for any write until rstN.
- R11: Writes to the limit at offsets 0x18 and 0x1C are accepted only while idle. Once the watchdog is armed or running, they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Byte offset of the write |
| wrData | input | 32 | Write data |
| timMode | input | 2 | Timer mode field; value 2 selects watchdog operation |
| halfRel | input | 2 | Release bits of the two timer halves; both must be 1 |
| rstReq | output | 1 | Single-cycle system reset request |

## Verification
The bench measures the exact firing latency for several limits, including zero. An off-by-one in the compare or the count clear shows up as a latency one clock early or late. A limit with a nonzero high word must not fire early. A design that compared only the low half would fire within a few clocks.

The bench checks service timing as well. A restart taken on the wrong key, or not taken at all, moves the firing point by a known number of clocks. Other probes cover the cases where the bench expects no reset: a wrong key while armed must not fire, a go key alone while running must not fire, and a cleared enable bit must not disarm. The bench also drops the timer mode in the middle of a count. A design that kept counting would fire early, and one that cleared the count would fire late.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;

  localparam int KEY_W  = 16;
  localparam int HALVES = 2;

  typedef enum logic [2:0] {
    WD_IDLE,
    WD_ARMED,
    WD_RUN,
    WD_HALFKEY,
    WD_TRIP
  } wdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              clrCnt;
    logic              incCnt;
    logic [HALVES-1:0] ldPrd;
  } dpCtl_t;

endpackage

// File: rtl/wdk_dp.sv
`timescale 1ns/1ps
module wdk_dp
  import wdk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   dpCtl,
  input  logic [DATA_W-1:0]        wrData,
  output logic                     cntMatch,
  output logic [HALVES*DATA_W-1:0] prdVal
);

  localparam int CNT_W = HALVES * DATA_W;

  logic [CNT_W-1:0] cntVal;

  // limit register, loaded one word at a time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prdVal <= '0;
    end else begin
      for (int h = 0; h < HALVES; h++) begin
        if (dpCtl.ldPrd[h]) prdVal[h*DATA_W +: DATA_W] <= wrData;
      end
    end
  end

  // running count; clear wins over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntVal <= '0;
    else if (dpCtl.clrCnt) cntVal <= '0;
    else if (dpCtl.incCnt) cntVal <= cntVal + CNT_W'(1);
  end

  assign cntMatch = (cntVal == prdVal);

endmodule

// File: rtl/wdk_ctrl.sv
`timescale 1ns/1ps
module wdk_ctrl
  import wdk_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          CTRL_OFS  = 'h28,
  parameter int          PRDLO_OFS = 'h18,
  parameter int          PRDHI_OFS = 'h1C,
  parameter int          MODE_W    = 2,
  parameter int          MODE_WDOG = 2,
  parameter logic [15:0] KEY_ARM   = 16'hA5C6,
  parameter logic [15:0] KEY_GO    = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic              wrEnBit,
  input  logic [MODE_W-1:0] timMode,
  input  logic [HALVES-1:0] halfRel,
  input  logic              cntMatch,
  output dpCtl_t            dpCtl,
  output wdState_t          curState,
  output logic              rstReq
);

  wdState_t nxtState;
  logic     modeOk;
  logic     ctrlWr;
  logic     fireNow;

  assign modeOk = (timMode == MODE_W'(MODE_WDOG)) && (&halfRel);
  assign ctrlWr = wrEn && (wrAddr == ADDR_W'(CTRL_OFS)) && modeOk;

  always_comb begin
    nxtState = curState;
    fireNow  = 1'b0;
    dpCtl    = '0;
    unique case (curState)
      WD_IDLE: begin
        dpCtl.ldPrd[0] = wrEn && (wrAddr == ADDR_W'(PRDLO_OFS));
        dpCtl.ldPrd[1] = wrEn && (wrAddr == ADDR_W'(PRDHI_OFS));
        if (ctrlWr && wrKey == KEY_ARM && wrEnBit) nxtState = WD_ARMED;
      end
      WD_ARMED: begin
        if (ctrlWr) begin
          if (wrKey == KEY_GO) begin
            nxtState     = WD_RUN;
            dpCtl.clrCnt = 1'b1;
          end else begin
            nxtState = WD_IDLE;
          end
        end
      end
      WD_RUN, WD_HALFKEY: begin
        if (modeOk) begin
          dpCtl.incCnt = 1'b1;
          if (cntMatch) begin
            fireNow = 1'b1;
          end else if (ctrlWr) begin
            if (wrKey == KEY_ARM) begin
              nxtState = WD_HALFKEY;
            end else if (wrKey == KEY_GO) begin
              if (curState == WD_HALFKEY) begin
                nxtState     = WD_RUN;
                dpCtl.clrCnt = 1'b1;
              end
            end else begin
              fireNow = 1'b1;
            end
          end
        end
        if (fireNow) nxtState = WD_TRIP;
      end
      default: nxtState = WD_TRIP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= WD_IDLE;
      rstReq   <= 1'b0;
    end else begin
      curState <= nxtState;
      rstReq   <= fireNow;
    end
  end

endmodule

// File: rtl/keyed_wdog_top.sv
`timescale 1ns/1ps
module keyed_wdog_top
  import wdk_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          EN_BIT    = 14,
  parameter int          CTRL_OFS  = 'h28,
  parameter int          PRDLO_OFS = 'h18,
  parameter int          PRDHI_OFS = 'h1C,
  parameter int          MODE_W    = 2,
  parameter int          MODE_WDOG = 2,
  parameter logic [15:0] KEY_ARM   = 16'hA5C6,
  parameter logic [15:0] KEY_GO    = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MODE_W-1:0] timMode,
  input  logic [HALVES-1:0] halfRel,
  output logic              rstReq
);

  dpCtl_t                   dpCtl;
  wdState_t                 curState;
  logic                     cntMatch;
  logic [HALVES*DATA_W-1:0] prdVal;

  wdk_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .PRDLO_OFS(PRDLO_OFS),
    .PRDHI_OFS(PRDHI_OFS), .MODE_W(MODE_W), .MODE_WDOG(MODE_WDOG),
    .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrKey(wrData[DATA_W-1 -: KEY_W]), .wrEnBit(wrData[EN_BIT]),
    .timMode(timMode), .halfRel(halfRel), .cntMatch(cntMatch),
    .dpCtl(dpCtl), .curState(curState), .rstReq(rstReq)
  );

  wdk_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .wrData(wrData),
    .cntMatch(cntMatch), .prdVal(prdVal)
  );

endmodule

// File: rtl/wdk_chk.sv
`timescale 1ns/1ps
module wdk_chk
  import wdk_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          CNT_W     = 64,
  parameter int          CTRL_OFS  = 'h28,
  parameter int          MODE_W    = 2,
  parameter int          MODE_WDOG = 2,
  parameter logic [15:0] KEY_GO    = 16'hDA7E
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [KEY_W-1:0]  wrKey,
  input logic [MODE_W-1:0] timMode,
  input logic [HALVES-1:0] halfRel,
  input logic              rstReq,
  input wdState_t          curState,
  input logic [CNT_W-1:0]  prdVal
);

  logic modeOk;
  assign modeOk = (timMode == MODE_W'(MODE_WDOG)) && (&halfRel);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!rstReq && curState == WD_IDLE));

  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == WD_IDLE && !modeOk) |=> curState == WD_IDLE);

  // R5
  armed_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == WD_ARMED && modeOk && wrEn && wrAddr == ADDR_W'(CTRL_OFS)
     && wrKey != KEY_GO) |=> (curState == WD_IDLE && !rstReq));

  // R7
  fire_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> ($past(curState) == WD_RUN || $past(curState) == WD_HALFKEY));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R10
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    curState == WD_TRIP |=> curState == WD_TRIP);

  // R11
  prd_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    curState != WD_IDLE |=> $stable(prdVal));

endmodule

bind keyed_wdog_top wdk_chk #(
  .ADDR_W(ADDR_W), .CNT_W(HALVES*DATA_W), .CTRL_OFS(CTRL_OFS),
  .MODE_W(MODE_W), .MODE_WDOG(MODE_WDOG), .KEY_GO(KEY_GO)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrKey(wrData[DATA_W-1 -: wdk_pkg::KEY_W]), .timMode(timMode),
  .halfRel(halfRel), .rstReq(rstReq), .curState(curState), .prdVal(prdVal)
);

// File: tb/sim_keyed_wdog_top.sv
`timescale 1ns/1ps
module sim_keyed_wdog_top;

  localparam logic [7:0]  A_CTRL = 8'h28;
  localparam logic [7:0]  A_PLO  = 8'h18;
  localparam logic [7:0]  A_PHI  = 8'h1C;
  localparam logic [31:0] W_ARM  = 32'hA5C6_4000;
  localparam logic [31:0] W_GO   = 32'hDA7E_4000;

  typedef struct packed {
    logic [31:0] prd;
    logic [31:0] lat;
  } vec_t;

  // limit, expected clocks from start write to rstReq (R6: P+1)
  localparam vec_t VEC [5] = '{
    '{32'd0,  32'd1},
    '{32'd1,  32'd2},
    '{32'd2,  32'd3},
    '{32'd7,  32'd8},
    '{32'd33, 32'd34}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  timMode = 2'd2;
  logic [1:0]  halfRel = 2'b11;
  logic        rstReq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  keyed_wdog_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timMode(timMode), .halfRel(halfRel), .rstReq(rstReq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog(all R) actual=%0d expected<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; timMode = 2'd2; halfRel = 2'b11;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic fireLat(input int maxN, output int n);
    n = -1;
    for (int i = 1; i <= maxN; i++) begin
      @(negedge clk);
      if (rstReq) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic quiet(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rstReq) hits++;
    end
  endtask

  task automatic startWd(input logic [31:0] lo, input logic [31:0] hi);
    wr(A_PLO, lo);
    wr(A_PHI, hi);
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, W_GO);
  endtask

  initial begin
    int n;
    int h;

    // R1: reset state, idle with zero limit never fires
    @(negedge clk);
    chk(rstReq == 1'b0, "R1 during reset", rstReq, 0);
    doReset();
    quiet(12, h);
    chk(h == 0, "R1 idle zero limit", h, 0);

    // R6: latency table
    for (int v = 0; v < 5; v++) begin
      doReset();
      startWd(VEC[v].prd, 32'd0);
      chk(rstReq == 1'b0, "R6 no pulse at start", rstReq, 0);
      fireLat(100, n);
      chk(n == int'(VEC[v].lat), "R6 latency", n, VEC[v].lat);
    end

    // R6: high word of limit takes part in compare
    doReset();
    startWd(32'd3, 32'd1);
    quiet(40, h);
    chk(h == 0, "R6 64-bit limit no early fire", h, 0);

    // R2: mode wrong, writes ignored
    doReset();
    timMode = 2'd1;
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, W_GO);
    timMode = 2'd2;
    quiet(6, h);
    chk(h == 0, "R2 mode off ignored", h, 0);
    halfRel = 2'b01;
    wr(A_CTRL, W_ARM);
    halfRel = 2'b11;
    wr(A_CTRL, W_GO);
    quiet(6, h);
    chk(h == 0, "R2 half in reset ignored; R4 go from idle ignored", h, 0);
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, W_GO);
    fireLat(10, n);
    chk(n == 1, "R2 works when released", n, 1);

    // R2: count holds while mode drops (limit 10, 3 used, 8 left)
    doReset();
    startWd(32'd10, 32'd0);
    repeat (3) @(negedge clk);
    halfRel = 2'b01;
    quiet(20, h);
    chk(h == 0, "R2 hold no fire", h, 0);
    halfRel = 2'b11;
    fireLat(30, n);
    chk(n == 8, "R2 count held", n, 8);

    // R3: enable bit 0 does not arm
    doReset();
    wr(A_CTRL, 32'hA5C6_0000);
    wr(A_CTRL, W_GO);
    quiet(8, h);
    chk(h == 0, "R3 arm needs enable", h, 0);
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, W_GO);
    fireLat(10, n);
    chk(n == 1, "R3 R4 arm then go", n, 1);

    // R5: wrong key while armed -> idle, no reset
    doReset();
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, 32'h1234_4000);
    chk(rstReq == 1'b0, "R5 no pulse on bad key armed", rstReq, 0);
    wr(A_CTRL, W_GO);
    quiet(8, h);
    chk(h == 0, "R5 back to idle", h, 0);

    // R11: limit write while armed ignored
    doReset();
    wr(A_CTRL, W_ARM);
    wr(A_PLO, 32'd5);
    wr(A_CTRL, W_GO);
    fireLat(20, n);
    chk(n == 1, "R11 limit locked", n, 1);

    // R7 + R10: bad key while running
    doReset();
    startWd(32'd40, 32'd0);
    quiet(3, h);
    wr(A_CTRL, 32'h0000_4000);
    chk(rstReq == 1'b1, "R7 bad key fires", rstReq, 1);
    @(negedge clk);
    chk(rstReq == 1'b0, "R10 single pulse", rstReq, 0);
    wr(A_CTRL, 32'h0000_4000);
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, W_GO);
    quiet(60, h);
    chk(h == 0, "R10 stays tripped", h, 0);

    // R8: service restarts count (limit 10)
    doReset();
    startWd(32'd10, 32'd0);
    repeat (4) @(negedge clk);
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, W_ARM);
    wr(A_CTRL, W_GO);
    chk(rstReq == 1'b0, "R8 no pulse on service", rstReq, 0);
    fireLat(30, n);
    chk(n == 11, "R8 restart latency", n, 11);

    // R9 + R7: enable 0 with go key, no disarm, no restart
    doReset();
    startWd(32'd10, 32'd0);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'hDA7E_0000);
    chk(rstReq == 1'b0, "R7 lone go key harmless", rstReq, 0);
    fireLat(30, n);
    chk(n == 8, "R9 enable ignored when running", n, 8);

    // R9: service with enable bit 0 still restarts
    doReset();
    startWd(32'd10, 32'd0);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'hA5C6_0000);
    wr(A_CTRL, 32'hDA7E_0000);
    fireLat(30, n);
    chk(n == 11, "R9 service with enable 0", n, 11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule